// File: doc/BRIEF.md
# Windowed Register File Controller

This block is a processor register file whose registers are organised as a ring of overlapping windows. A procedure sees 32 architectural register numbers: a small global set that every procedure shares, and three window-relative groups (incoming arguments, private locals and outgoing arguments). The outgoing group of one window is the same storage as the incoming group of the next window around the ring. A call therefore hands arguments to the callee with no copying, and a return hands results back the same way.

A current-window pointer selects the visible window and rotates one step on a call and one step back on a return. A second pointer marks the most recently saved window. When a call would run into it, the block raises an overflow trap and asks an external agent to spill the oldest resident window. When a return lands on a window that has been saved, the block raises an underflow trap and asks for a fill. The memory transfer itself happens outside the block. The block only signals which window to move and waits for an acknowledge.

Top module: `win_regfile`

## Requirements
- R1: After reset the current window is 0, the saved-window pointer is 5, spillReq and fillReq are low, and every register reads zero.
- R2: Index 0 always reads zero, and a write to index 0 has no effect.
- R3: Indices 1 to 7 are global registers that hold the same value in every window.
- R4: Writes take effect at the rising clock edge using the window that is current before that edge. Both read ports are combinational and independent.
- R5: A call taken in the idle state, with no overflow, moves curWin to (curWin+1) mod 6 at the next edge. A return taken with no underflow moves curWin to (curWin+5) mod 6.
- R6: Indices 24 to 31 (outgoing) in window w are the same registers as indices 8 to 15 (incoming) in window (w+1) mod 6.
- R7: Indices 16 to 23 (locals) are private to each window, and a call followed by a return leaves them intact.
- R8: A call for which (curWin+1) mod 6 equals the saved pointer raises ovfTrap in that cycle and leaves curWin unchanged. From the next cycle spillReq is high and xferWin is (saved+1) mod 6. On xferAck both pointers advance by one.
- R9: A return for which (curWin+5) mod 6 equals the saved pointer raises unfTrap in that cycle and leaves curWin unchanged. From the next cycle fillReq is high and xferWin equals the saved pointer. On xferAck both pointers step back by one.
- R10: While spillReq or fillReq is high, call and ret are ignored and curWin holds until xferAck.
- R11: Starting from reset, four calls complete without a trap and the fifth call raises ovfTrap with xferWin 0.
- R12: When call and ret are both high in the idle state, the call is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rdIdxA | input | 5 | Architectural index, read port A |
| rdIdxB | input | 5 | Architectural index, read port B |
| rdDataA | output | 32 | Read data, port A |
| rdDataB | output | 32 | Read data, port B |
| wrEn | input | 1 | Write enable |
| wrIdx | input | 5 | Architectural write index |
| wrData | input | 32 | Write data |
| call | input | 1 | Procedure call request |
| ret | input | 1 | Procedure return request |
| ovfTrap | output | 1 | Call hit the saved window |
| unfTrap | output | 1 | Return target is saved in memory |
| spillReq | output | 1 | Spill of window xferWin pending |
| fillReq | output | 1 | Fill of window xferWin pending |
| xferWin | output | 3 | Window to spill or fill |
| xferAck | input | 1 | External transfer finished |
| curWin | output | 3 | Current window pointer |

## Verification
A wrong current-window pointer shows up at the next call or return: curWin moves to the wrong value, and reads of the incoming, local or outgoing groups return data written from another window. A wrong saved pointer stays hidden until the ring fills or drains. It then shows as a trap that arrives one call early or late, or as a wrong xferWin, which can be several calls after the faulty update. For that reason the random stimulus keeps the call depth moving across the whole ring many times, and every cycle it compares the traps, the request lines and both read ports with an independent model.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
  // Window pointer width; holds ring sizes up to 8 windows.
  localparam int PTRW = 3;

  // Strobes from control to datapath.
  typedef struct packed {
    logic [PTRW-1:0] cwp;   // visible window
  } winSel_t;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SPILL = 2'd1,
    ST_FILL  = 2'd2
  } ctlState_t;
endpackage

// File: rtl/rwf_ctrl.sv
module rwf_ctrl
  import rwf_pkg::*;
#(
  parameter int NWIN = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            call,
  input  logic            ret,
  input  logic            xferAck,
  output winSel_t         sel,
  output logic            ovfTrap,
  output logic            unfTrap,
  output logic            spillReq,
  output logic            fillReq,
  output logic [PTRW-1:0] xferWin
);
  localparam logic [PTRW-1:0] LASTWIN = PTRW'(NWIN - 1);

  function automatic logic [PTRW-1:0] stepUp(input logic [PTRW-1:0] p);
    return (p == LASTWIN) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTRW-1:0] stepDn(input logic [PTRW-1:0] p);
    return (p == '0) ? LASTWIN : p - 1'b1;
  endfunction

  ctlState_t       state;
  logic [PTRW-1:0] cwp, swp;
  logic            callTake, retTake;

  always_comb begin
    callTake = (state == ST_RUN) && call;
    retTake  = (state == ST_RUN) && ret && !call;
    ovfTrap  = callTake && (stepUp(cwp) == swp);
    unfTrap  = retTake && (stepDn(cwp) == swp);
    spillReq = (state == ST_SPILL);
    fillReq  = (state == ST_FILL);
    xferWin  = (state == ST_SPILL) ? stepUp(swp) : swp;
    sel.cwp  = cwp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_RUN;
      cwp   <= '0;
      swp   <= LASTWIN;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (ovfTrap)       state <= ST_SPILL;
          else if (unfTrap)  state <= ST_FILL;
          else if (callTake) cwp <= stepUp(cwp);
          else if (retTake)  cwp <= stepDn(cwp);
        end
        ST_SPILL: if (xferAck) begin
          swp   <= stepUp(swp);
          cwp   <= stepUp(cwp);
          state <= ST_RUN;
        end
        ST_FILL: if (xferAck) begin
          swp   <= stepDn(swp);
          cwp   <= stepDn(cwp);
          state <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/rwf_datapath.sv
module rwf_datapath
  import rwf_pkg::*;
#(
  parameter int NWIN = 6,
  parameter int FSZ  = 8,
  parameter int DW   = 32,
  parameter int IW   = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  winSel_t       sel,
  input  logic [IW-1:0] rdIdxA,
  input  logic [IW-1:0] rdIdxB,
  output logic [DW-1:0] rdDataA,
  output logic [DW-1:0] rdDataB,
  input  logic          wrEn,
  input  logic [IW-1:0] wrIdx,
  input  logic [DW-1:0] wrData
);
  // Globals occupy the first group; each window owns an incoming
  // group and a local group; its outgoing group is the next window's incoming.
  localparam int GRPSZ = 2 * FSZ;
  localparam int NPHY  = FSZ + NWIN * GRPSZ;
  localparam int PW    = $clog2(NPHY);

  function automatic logic [PW-1:0] physOf(input logic [PTRW-1:0] cw,
                                           input logic [IW-1:0] idx);
    int rel, fld, off, grp;
    if (int'(idx) < FSZ) return PW'(idx);
    rel = int'(idx) - FSZ;
    fld = rel / FSZ;
    off = rel % FSZ;
    grp = int'(cw);
    if (fld == 2) grp = (grp == NWIN - 1) ? 0 : grp + 1;
    return PW'(FSZ + grp * GRPSZ + ((fld == 1) ? FSZ : 0) + off);
  endfunction

  logic [DW-1:0] regs [NPHY];
  logic [PW-1:0] wrPhys;

  assign wrPhys = physOf(sel.cwp, wrIdx);

  for (genvar p = 0; p < NPHY; p++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)
        regs[p] <= '0;
      else if (wrEn && (wrIdx != '0) && (wrPhys == PW'(p)))
        regs[p] <= wrData;
    end
  end

  always_comb begin
    rdDataA = (rdIdxA == '0) ? '0 : regs[physOf(sel.cwp, rdIdxA)];
    rdDataB = (rdIdxB == '0) ? '0 : regs[physOf(sel.cwp, rdIdxB)];
  end
endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import rwf_pkg::*;
#(
  parameter int NWIN = 6,
  parameter int FSZ  = 8,
  parameter int DW   = 32,
  parameter int IW   = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [IW-1:0]   rdIdxA,
  input  logic [IW-1:0]   rdIdxB,
  output logic [DW-1:0]   rdDataA,
  output logic [DW-1:0]   rdDataB,
  input  logic            wrEn,
  input  logic [IW-1:0]   wrIdx,
  input  logic [DW-1:0]   wrData,
  input  logic            call,
  input  logic            ret,
  output logic            ovfTrap,
  output logic            unfTrap,
  output logic            spillReq,
  output logic            fillReq,
  output logic [PTRW-1:0] xferWin,
  input  logic            xferAck,
  output logic [PTRW-1:0] curWin
);
  winSel_t sel;

  rwf_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .call(call), .ret(ret), .xferAck(xferAck),
    .sel(sel), .ovfTrap(ovfTrap), .unfTrap(unfTrap),
    .spillReq(spillReq), .fillReq(fillReq), .xferWin(xferWin)
  );

  rwf_datapath #(.NWIN(NWIN), .FSZ(FSZ), .DW(DW), .IW(IW)) u_dp (
    .clk(clk), .rstN(rstN), .sel(sel),
    .rdIdxA(rdIdxA), .rdIdxB(rdIdxB), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData)
  );

  assign curWin = sel.cwp;
endmodule

// File: rtl/win_regfile_chk.sv
module win_regfile_chk
  import rwf_pkg::*;
#(
  parameter int NWIN = 6,
  parameter int DW   = 32,
  parameter int IW   = 5
) (
  input logic            clk,
  input logic            rstN,
  input logic [IW-1:0]   rdIdxA,
  input logic [DW-1:0]   rdDataA,
  input logic            call,
  input logic            ret,
  input logic            ovfTrap,
  input logic            unfTrap,
  input logic            spillReq,
  input logic            fillReq,
  input logic            xferAck,
  input logic [PTRW-1:0] curWin
);
  localparam logic [PTRW-1:0] LASTWIN = PTRW'(NWIN - 1);
  logic busy;
  assign busy = spillReq || fillReq;

  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdxA == '0) |-> (rdDataA == '0));                                     // R2
  AST_CALL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && call && !ovfTrap) |=>
      (curWin == (($past(curWin) == LASTWIN) ? '0 : $past(curWin) + 1'b1))); // R5
  AST_RET_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && ret && !call && !unfTrap) |=>
      (curWin == (($past(curWin) == '0) ? LASTWIN : $past(curWin) - 1'b1))); // R5
  AST_OVF_SPILL: assert property (@(posedge clk) disable iff (!rstN)
    ovfTrap |=> (spillReq && $stable(curWin)));                              // R8
  AST_UNF_FILL: assert property (@(posedge clk) disable iff (!rstN)
    unfTrap |=> (fillReq && $stable(curWin)));                               // R9
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !xferAck) |=> (busy && $stable(curWin)));                       // R10
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({spillReq, fillReq, ovfTrap, unfTrap}));                        // R10
  AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    curWin <= LASTWIN);                                                      // R5
endmodule

bind win_regfile win_regfile_chk #(.NWIN(NWIN), .DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rstN(rstN), .rdIdxA(rdIdxA), .rdDataA(rdDataA),
  .call(call), .ret(ret), .ovfTrap(ovfTrap), .unfTrap(unfTrap),
  .spillReq(spillReq), .fillReq(fillReq), .xferAck(xferAck), .curWin(curWin)
);

// File: tb/win_regfile_test.sv
module win_regfile_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  rdIdxA = '0, rdIdxB = '0, wrIdx = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0;
  logic        wrEn = 1'b0, call = 1'b0, ret = 1'b0, xferAck = 1'b0;
  logic        ovfTrap, unfTrap, spillReq, fillReq;
  logic [2:0]  xferWin, curWin;

  int checks = 0;
  int errors = 0;

  // Reference model state.
  logic [31:0] mMem [104];
  int mCwp, mSwp, mSt;   // mSt: 0 run, 1 spill, 2 fill

  always #4 clk = ~clk;

  win_regfile uut (
    .clk(clk), .rstN(rstN), .rdIdxA(rdIdxA), .rdIdxB(rdIdxB),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrData(wrData), .call(call), .ret(ret), .ovfTrap(ovfTrap),
    .unfTrap(unfTrap), .spillReq(spillReq), .fillReq(fillReq),
    .xferWin(xferWin), .xferAck(xferAck), .curWin(curWin)
  );

  function automatic int up6(int p); return (p + 1) % 6; endfunction
  function automatic int dn6(int p); return (p + 5) % 6; endfunction

  function automatic int mPhys(int cw, int idx);
    if (idx < 8)  return idx;
    if (idx < 16) return 8 + cw * 16 + (idx - 8);
    if (idx < 24) return 16 + cw * 16 + (idx - 16);
    return 8 + up6(cw) * 16 + (idx - 24);
  endfunction

  function automatic logic [31:0] mRead(int idx);
    return (idx == 0) ? 32'd0 : mMem[mPhys(mCwp, idx)];
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every output with the model, then clock once and update it.
  task automatic step(input string tag);
    logic eOvf, eUnf;
    #1;
    eOvf = (mSt == 0) && call && (up6(mCwp) == mSwp);
    eUnf = (mSt == 0) && ret && !call && (dn6(mCwp) == mSwp);
    chk(32'(curWin), 32'(mCwp), {tag, " curWin"});
    chk(32'(ovfTrap), 32'(eOvf), {tag, " ovfTrap"});
    chk(32'(unfTrap), 32'(eUnf), {tag, " unfTrap"});
    chk(32'(spillReq), 32'(mSt == 1), {tag, " spillReq"});
    chk(32'(fillReq), 32'(mSt == 2), {tag, " fillReq"});
    if (mSt == 1) chk(32'(xferWin), 32'(up6(mSwp)), {tag, " xferWin"});
    if (mSt == 2) chk(32'(xferWin), 32'(mSwp), {tag, " xferWin"});
    chk(rdDataA, mRead(int'(rdIdxA)), {tag, " rdDataA"});
    chk(rdDataB, mRead(int'(rdIdxB)), {tag, " rdDataB"});
    @(posedge clk);
    if (wrEn && wrIdx != 0) mMem[mPhys(mCwp, int'(wrIdx))] = wrData;
    case (mSt)
      0: if (eOvf) mSt = 1;
         else if (eUnf) mSt = 2;
         else if (call) mCwp = up6(mCwp);
         else if (ret) mCwp = dn6(mCwp);
      1: if (xferAck) begin mSwp = up6(mSwp); mCwp = up6(mCwp); mSt = 0; end
      default: if (xferAck) begin mSwp = dn6(mSwp); mCwp = dn6(mCwp); mSt = 0; end
    endcase
    @(negedge clk);
    wrEn = 0; call = 0; ret = 0; xferAck = 0;
  endtask

  task automatic wr(input int idx, input logic [31:0] d, input string tag);
    wrEn = 1; wrIdx = 5'(idx); wrData = d; step(tag);
  endtask

  task automatic rd(input int a, input int b, input logic [31:0] ea,
                    input logic [31:0] eb, input string tag);
    rdIdxA = 5'(a); rdIdxB = 5'(b); #1;
    chk(rdDataA, ea, {tag, " port A"});
    chk(rdDataB, eb, {tag, " port B"});
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 104; i++) mMem[i] = '0;
    mCwp = 0; mSwp = 5; mSt = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset state
    chk(32'(curWin), 0, "R1 curWin");
    chk(32'(spillReq | fillReq), 0, "R1 requests");
    rd(5, 20, 0, 0, "R1 regs zero");
    // R2: index 0
    wr(0, 32'hDEAD_BEEF, "R2 write idx0");
    rd(0, 0, 0, 0, "R2 idx0 reads zero");
    // R4: write then read back on both ports
    wr(3, 32'h0000_0A03, "R4 write global");
    wr(24, 32'h0000_0B24, "R4 write temp");
    wr(16, 32'h0000_0C16, "R4 write local");
    rd(3, 24, 32'h0A03, 32'h0B24, "R4 two ports");
    // R5/R6/R7/R3 across a call
    call = 1; step("R5 call");
    chk(32'(curWin), 1, "R5 curWin after call");
    rd(8, 16, 32'h0B24, 0, "R6 overlap / R7 private local");
    rd(3, 0, 32'h0A03, 0, "R3 global visible");
    wr(16, 32'h0000_1116, "R7 write callee local");
    // R11: three more calls, then the fifth overflows
    call = 1; step("R11 call2");
    call = 1; step("R11 call3");
    call = 1; step("R11 call4");
    chk(32'(curWin), 4, "R11 depth 4");
    call = 1; #1;
    chk(32'(ovfTrap), 1, "R11 fifth call traps");
    step("R8 overflow");
    chk(32'(spillReq), 1, "R8 spillReq");
    chk(32'(xferWin), 0, "R8 spill window");
    chk(32'(curWin), 4, "R8 cwp held");
    // R10: call and ret ignored while pending
    call = 1; step("R10 call ignored");
    ret = 1; step("R10 ret ignored");
    chk(32'(curWin), 4, "R10 cwp held");
    xferAck = 1; step("R8 ack");
    chk(32'(curWin), 5, "R8 cwp after spill");
    chk(32'(spillReq), 0, "R8 spill done");
    // Return down to window 1, then underflow into saved window 0
    for (int k = 0; k < 4; k++) begin ret = 1; step("R5 ret"); end
    chk(32'(curWin), 1, "R5 back at 1");
    rd(16, 0, 32'h1116, 0, "R7 callee local kept");
    ret = 1; #1;
    chk(32'(unfTrap), 1, "R9 underflow trap");
    step("R9 underflow");
    chk(32'(fillReq), 1, "R9 fillReq");
    chk(32'(xferWin), 0, "R9 fill window");
    xferAck = 1; step("R9 ack");
    chk(32'(curWin), 0, "R9 cwp after fill");
    rd(16, 3, 32'h0C16, 32'h0A03, "R7 caller local kept");
    // R12: call wins over ret
    call = 1; ret = 1; step("R12 both");
    chk(32'(curWin), 1, "R12 call taken");

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      wrEn = ($urandom_range(0, 1) == 1);
      wrIdx = 5'($urandom_range(0, 31));
      wrData = $urandom();
      rdIdxA = 5'($urandom_range(0, 31));
      rdIdxB = 5'($urandom_range(0, 31));
      call = (r < 30) || (r >= 90);
      ret = (r >= 30 && r < 60) || (r >= 95);
      xferAck = ($urandom_range(0, 2) == 0);
      step("R4 R5 R8 R9 R10 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule